// File: doc/BRIEF.md
# DMA Major-Loop Iteration Counter with Channel Linking

This block keeps the major-loop iteration state of a single DMA channel descriptor. Software writes two 16-bit words, the current count word and the beginning count word, through a load port. Each minor loop the transfer engine finishes is reported on `minor_done`. The block then steps the current count down. On the final iteration it restores the current count from the beginning count.

The top bit of each word turns on linking to another channel. With that bit set, the word holds a 6-bit target channel and a 9-bit count. With it clear, the word holds a single 15-bit count. When linking is on, every minor loop that does not end the major loop sends a one-cycle start strobe with the target channel index. The strobe tells a neighbouring channel to begin service. On the iteration that ends the major loop, this per-minor-loop link is replaced by the major-loop link setting, which arrives on its own pins.

A descriptor whose two words differ, or whose count field is zero, is flagged as a configuration error. While the error flag is set, the channel does not count.

The load port is a valid/ready input. A word pair is taken on a rising edge where `load_valid` and `load_ready` are both high. `load_ready` drops in any cycle where `minor_done` is high, because a minor-loop completion in that cycle takes priority. A source that sees `load_ready` low must hold its words and keep `load_valid` high. All other pins are plain level or pulse signals.

Top module: `dma_iter_link`

## Requirements
- R1: After reset, `cfg_err`, `link_req`, `major_done` and `cur_iter` are all zero, and `load_ready` is high while `minor_done` is low.
- R2: Word format. Bit 15 is the link enable. When it is 1, bits 14:9 are the target channel and bits 8:0 are the count. When it is 0, bits 14:0 are the count. `cur_iter` shows the count field of the stored current word, zero-extended to 15 bits.
- R3: A load is taken only on an edge where `load_valid` and `load_ready` are both high. `load_ready` is low in every cycle where `minor_done` is high, and the load offered in such a cycle has no effect.
- R4: A load whose two 16-bit words differ sets `cfg_err` in the cycle after the load.
- R5: A load whose count field is zero sets `cfg_err` in the cycle after the load.
- R6: Once set, `cfg_err` stays set until `err_clear` is pulsed or a valid descriptor is loaded.
- R7: A `minor_done` pulse has no effect while `cfg_err` is set or while the current count is zero. The count does not change and no strobe is raised.
- R8: A `minor_done` pulse with a count above 1 lowers `cur_iter` by one in the next cycle. If the stored link enable is 1, the same pulse raises `link_req` for one cycle, with `link_ch` set to the stored channel.
- R9: A `minor_done` pulse with a count of 1 does three things in the next cycle. It restores the current word from the beginning word. It raises `major_done` for one cycle. It raises `link_req` only if `major_link_en` is 1, with `link_ch` taken from `major_link_ch`; the per-minor-loop link is suppressed.
- R10: A descriptor loaded with both counts equal to 1 raises `major_done` on every accepted `minor_done` pulse, and `cur_iter` stays at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_valid | input | 1 | Descriptor word pair offered |
| load_ready | output | 1 | Descriptor word pair can be taken this cycle |
| load_citer | input | 16 | Current count word |
| load_biter | input | 16 | Beginning count word |
| minor_done | input | 1 | One-cycle pulse: a minor loop finished |
| major_link_en | input | 1 | Link to a channel when the major loop ends |
| major_link_ch | input | 6 | Channel to start when the major loop ends |
| err_clear | input | 1 | Clears the configuration error |
| link_req | output | 1 | One-cycle start strobe for the channel on `link_ch` |
| link_ch | output | 6 | Target channel of the start strobe |
| major_done | output | 1 | One-cycle pulse: the major loop ended |
| cfg_err | output | 1 | Configuration error pending |
| cur_iter | output | 15 | Count field of the current word |

## Verification
The assertions watch several properties on every clock edge:
- a mismatched load always raises the error;
- the error stays set with no clear and no load;
- the current word does not change without a load or an accepted minor loop;
- a step above 1 decrements the count by one;
- the final step restores the beginning word;
- the minor-loop link never appears on the final step when the major link is disabled.

Only the bench scenarios can show the following:
- the two word layouts, including that the channel bits never count;
- the exact channel numbers put out on each kind of strobe;
- that a valid reload clears the error and a zero count sets it;
- that a load offered in the same cycle as a minor-loop completion is dropped.

// File: rtl/dma_iter_pkg.sv
package dma_iter_pkg;

  // Outcome of one accepted minor-loop completion
  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_DEC  = 2'd1,
    STEP_WRAP = 2'd2
  } step_kind_t;

endpackage

// File: rtl/dma_iter_loadchk.sv
module dma_iter_loadchk #(
  parameter int CNT_W = 15,
  parameter int CH_W  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_fire,
  input  logic [CNT_W:0]   citer_w,
  input  logic [CNT_W:0]   biter_w,
  input  logic             err_clear,
  output logic             cfg_err
);
  localparam int LNK_CNT_W = CNT_W - CH_W;

  logic [CNT_W-1:0] b_cnt;
  logic             bad;

  // Count field of the beginning word, layout picked by its link-enable bit
  always_comb begin
    if (biter_w[CNT_W]) b_cnt = CNT_W'(biter_w[LNK_CNT_W-1:0]);
    else                b_cnt = biter_w[CNT_W-1:0];
  end

  assign bad = (citer_w != biter_w) || (b_cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cfg_err <= 1'b0;
    else if (load_fire) cfg_err <= bad;
    else if (err_clear) cfg_err <= 1'b0;
  end

  a_r4_mismatch_flags: assert property (@(posedge clk) disable iff (!rst_n)
    load_fire && (citer_w != biter_w) |=> cfg_err);

  a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err && !load_fire && !err_clear |=> cfg_err);

endmodule

// File: rtl/dma_iter_count.sv
module dma_iter_count
  import dma_iter_pkg::*;
#(
  parameter int CNT_W = 15,
  parameter int CH_W  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_fire,
  input  logic [CNT_W:0]   load_citer,
  input  logic [CNT_W:0]   load_biter,
  input  logic             step,
  output logic [CNT_W-1:0] cur_cnt,
  output logic             cur_lnk_en,
  output logic [CH_W-1:0]  cur_lnk_ch,
  output step_kind_t       kind
);
  localparam int LNK_CNT_W = CNT_W - CH_W;

  logic [CNT_W:0] citer_q;
  logic [CNT_W:0] biter_q;

  always_comb begin
    if (citer_q[CNT_W]) cur_cnt = CNT_W'(citer_q[LNK_CNT_W-1:0]);
    else                cur_cnt = citer_q[CNT_W-1:0];
  end

  assign cur_lnk_en = citer_q[CNT_W];
  assign cur_lnk_ch = citer_q[CNT_W-1 -: CH_W];

  always_comb begin
    if (!step)                        kind = STEP_NONE;
    else if (cur_cnt == CNT_W'(1))    kind = STEP_WRAP;
    else                              kind = STEP_DEC;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      citer_q <= '0;
      biter_q <= '0;
    end else if (load_fire) begin
      citer_q <= load_citer;
      biter_q <= load_biter;
    end else begin
      case (kind)
        STEP_WRAP: citer_q <= biter_q;
        // The count is at least 2 here, so the low bits never borrow into the
        // channel or enable bits in either layout
        STEP_DEC:  citer_q <= citer_q - 1'b1;
        default:   citer_q <= citer_q;
      endcase
    end
  end

  a_r9_reload_from_begin: assert property (@(posedge clk) disable iff (!rst_n)
    !load_fire && (kind == STEP_WRAP) |=> citer_q == $past(biter_q));

  a_r8_decrement_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    !load_fire && (kind == STEP_DEC) |=> cur_cnt == $past(cur_cnt) - CNT_W'(1));

  a_r7_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !load_fire && !step |=> $stable(citer_q));

endmodule

// File: rtl/dma_iter_link_sel.sv
module dma_iter_link_sel
  import dma_iter_pkg::*;
#(
  parameter int CH_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  step_kind_t      kind,
  input  logic            minor_en,
  input  logic [CH_W-1:0] minor_ch,
  input  logic            major_en,
  input  logic [CH_W-1:0] major_ch,
  output logic            link_req,
  output logic [CH_W-1:0] link_ch,
  output logic            major_done
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      link_req   <= 1'b0;
      link_ch    <= '0;
      major_done <= 1'b0;
    end else begin
      link_req   <= 1'b0;
      major_done <= 1'b0;
      case (kind)
        STEP_DEC: begin
          link_req <= minor_en;
          link_ch  <= minor_ch;
        end
        STEP_WRAP: begin
          // The major-loop link replaces the per-minor-loop link
          major_done <= 1'b1;
          link_req   <= major_en;
          link_ch    <= major_ch;
        end
        default: ;
      endcase
    end
  end

  a_r9_minor_link_suppressed: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == STEP_WRAP) && !major_en |=> !link_req);

  a_r8_strobe_needs_step: assert property (@(posedge clk) disable iff (!rst_n)
    link_req |-> $past(kind) != STEP_NONE);

endmodule

// File: rtl/dma_iter_link.sv
module dma_iter_link
  import dma_iter_pkg::*;
#(
  parameter int CNT_W = 15,
  parameter int CH_W  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_valid,
  output logic             load_ready,
  input  logic [CNT_W:0]   load_citer,
  input  logic [CNT_W:0]   load_biter,
  input  logic             minor_done,
  input  logic             major_link_en,
  input  logic [CH_W-1:0]  major_link_ch,
  input  logic             err_clear,
  output logic             link_req,
  output logic [CH_W-1:0]  link_ch,
  output logic             major_done,
  output logic             cfg_err,
  output logic [CNT_W-1:0] cur_iter
);
  logic             load_fire;
  logic             step;
  logic             cur_lnk_en;
  logic [CH_W-1:0]  cur_lnk_ch;
  step_kind_t       kind;

  assign load_ready = !minor_done;
  assign load_fire  = load_valid && load_ready;
  assign step       = minor_done && !cfg_err && (cur_iter != '0);

  dma_iter_loadchk #(.CNT_W(CNT_W), .CH_W(CH_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_fire (load_fire),
    .citer_w   (load_citer),
    .biter_w   (load_biter),
    .err_clear (err_clear),
    .cfg_err   (cfg_err)
  );

  dma_iter_count #(.CNT_W(CNT_W), .CH_W(CH_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_fire  (load_fire),
    .load_citer (load_citer),
    .load_biter (load_biter),
    .step       (step),
    .cur_cnt    (cur_iter),
    .cur_lnk_en (cur_lnk_en),
    .cur_lnk_ch (cur_lnk_ch),
    .kind       (kind)
  );

  dma_iter_link_sel #(.CH_W(CH_W)) u_lnk (
    .clk        (clk),
    .rst_n      (rst_n),
    .kind       (kind),
    .minor_en   (cur_lnk_en),
    .minor_ch   (cur_lnk_ch),
    .major_en   (major_link_en),
    .major_ch   (major_link_ch),
    .link_req   (link_req),
    .link_ch    (link_ch),
    .major_done (major_done)
  );

  a_r7_no_strobe_in_error: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err && !load_fire |=> !major_done && !link_req);

endmodule

// File: tb/dma_iter_link_test.sv
`timescale 1ns/1ps
module dma_iter_link_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_valid = 1'b0;
  logic        load_ready;
  logic [15:0] load_citer = '0;
  logic [15:0] load_biter = '0;
  logic        minor_done = 1'b0;
  logic        major_link_en = 1'b0;
  logic [5:0]  major_link_ch = '0;
  logic        err_clear = 1'b0;
  logic        link_req;
  logic [5:0]  link_ch;
  logic        major_done;
  logic        cfg_err;
  logic [14:0] cur_iter;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  dma_iter_link uut (
    .clk(clk), .rst_n(rst_n), .load_valid(load_valid), .load_ready(load_ready),
    .load_citer(load_citer), .load_biter(load_biter), .minor_done(minor_done),
    .major_link_en(major_link_en), .major_link_ch(major_link_ch),
    .err_clear(err_clear), .link_req(link_req), .link_ch(link_ch),
    .major_done(major_done), .cfg_err(cfg_err), .cur_iter(cur_iter)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic expect_eq(input string req, input int act, input int exp);
    check(act == exp, req, act, exp);
  endtask

  task automatic do_load(input logic [15:0] c, input logic [15:0] b);
    @(negedge clk);
    load_citer = c; load_biter = b; load_valid = 1'b1;
    @(negedge clk);
    load_valid = 1'b0;
  endtask

  task automatic do_minor();
    @(negedge clk);
    minor_done = 1'b1;
    @(negedge clk);
    minor_done = 1'b0;
  endtask

  task automatic t_reset();
    expect_eq("R1 cfg_err", cfg_err, 0);
    expect_eq("R1 cur_iter", cur_iter, 0);
    expect_eq("R1 link_req", link_req, 0);
    expect_eq("R1 major_done", major_done, 0);
    expect_eq("R1 load_ready", load_ready, 1);
    do_minor();
    expect_eq("R7 zero count ignored", cur_iter, 0);
    expect_eq("R7 no major_done on zero count", major_done, 0);
  endtask

  task automatic t_unlinked();
    do_load(16'h0003, 16'h0003);
    expect_eq("R2 unlinked count", cur_iter, 3);
    expect_eq("R6 valid load no err", cfg_err, 0);
    do_minor();
    expect_eq("R8 decrement", cur_iter, 2);
    expect_eq("R8 no link when disabled", link_req, 0);
    do_minor();
    expect_eq("R8 decrement again", cur_iter, 1);
    major_link_en = 1'b1; major_link_ch = 6'd5;
    do_minor();
    expect_eq("R9 major_done", major_done, 1);
    expect_eq("R9 major link", link_req, 1);
    expect_eq("R9 major link ch", link_ch, 5);
    expect_eq("R9 reload", cur_iter, 3);
    @(negedge clk);
    expect_eq("R9 major_done one cycle", major_done, 0);
    expect_eq("R9 link one cycle", link_req, 0);
    major_link_en = 1'b0;
  endtask

  task automatic t_linked();
    // enable=1, channel 7, count 2
    do_load(16'h8E02, 16'h8E02);
    expect_eq("R2 linked count excludes channel", cur_iter, 2);
    do_minor();
    expect_eq("R8 minor link", link_req, 1);
    expect_eq("R8 minor link ch", link_ch, 7);
    expect_eq("R8 linked decrement", cur_iter, 1);
    major_link_ch = 6'd9;
    do_minor();
    expect_eq("R9 wrap major_done", major_done, 1);
    expect_eq("R9 minor link suppressed", link_req, 0);
    expect_eq("R9 linked reload", cur_iter, 2);
  endtask

  task automatic t_mismatch();
    do_load(16'h0004, 16'h0005);
    expect_eq("R4 mismatch err", cfg_err, 1);
    do_minor();
    expect_eq("R7 count held in error", cur_iter, 4);
    expect_eq("R7 no link in error", link_req, 0);
    expect_eq("R7 no major in error", major_done, 0);
    @(negedge clk);
    expect_eq("R6 err sticky", cfg_err, 1);
    err_clear = 1'b1;
    @(negedge clk);
    err_clear = 1'b0;
    expect_eq("R6 err cleared", cfg_err, 0);
    do_minor();
    expect_eq("R8 counts after clear", cur_iter, 3);
  endtask

  task automatic t_zero_and_single();
    do_load(16'h0000, 16'h0000);
    expect_eq("R5 zero count err", cfg_err, 1);
    do_load(16'h8A00, 16'h8A00);
    expect_eq("R5 zero linked count err", cfg_err, 1);
    do_load(16'h0001, 16'h0001);
    expect_eq("R6 valid load clears err", cfg_err, 0);
    expect_eq("R10 single count", cur_iter, 1);
    do_minor();
    expect_eq("R10 major_done first", major_done, 1);
    expect_eq("R10 stays 1", cur_iter, 1);
    do_minor();
    expect_eq("R10 major_done second", major_done, 1);
  endtask

  task automatic t_ready();
    @(negedge clk);
    minor_done = 1'b1;
    load_valid = 1'b1; load_citer = 16'h0009; load_biter = 16'h0009;
    #1;
    expect_eq("R3 ready low with minor_done", load_ready, 0);
    @(negedge clk);
    minor_done = 1'b0; load_valid = 1'b0;
    expect_eq("R3 load dropped", cur_iter, 1);
    expect_eq("R3 minor still served", major_done, 1);
  endtask

  initial begin
    #5_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_unlinked();
    t_linked();
    t_mismatch();
    t_zero_and_single();
    t_ready();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule